// File: doc/BRIEF.md
# Serial Capture Controller for a Self-Clocked Sampling Converter

This block sits on the host side of a 12-bit sampling converter that clocks its own result out serially. The host raises `start`. The controller then drives the active-low convert and select lines low together for a programmed number of system clocks, and that pulse begins a conversion. While the conversion runs, the converter emits 12 data-clock pulses with the result, MSB first. The word it emits belongs to the conversion before, so the pipeline is one deep. After the last pulse the data line holds a tag level. The incoming data clock, data line and busy flag are all passed through two-flop synchronizers into the system clock domain. A bit is taken on each synchronized rising edge of the data clock.

The busy flag goes low during a conversion and rises again at its end. That rising edge is the latch point. If all 12 bits have arrived, the controller presents the word and the tag together with a one-cycle valid pulse. The first word after reset carries an invalid marker, because no earlier conversion exists. Two faults are reported as one-cycle pulses: busy rising before all 12 bits have arrived, and busy not rising within a programmed window. A throughput counter keeps the next conversion from starting until a programmed interval has passed since the last start.

The state machine has five states: IDLE, CONV, WAIT, DONE and FAIL. Its transitions are:
- IDLE→CONV when `start` is high and the interval has elapsed.
- CONV→WAIT when the pulse count is reached.
- WAIT→DONE when busy rises with 12 bits.
- WAIT→FAIL when busy rises early with fewer bits, or when the timeout expires.
- DONE→IDLE and FAIL→IDLE unconditionally.

Top module: `adc_serial_cap`

## Requirements
- R1: With `start` high in IDLE and the throughput interval elapsed, `conv_n` and `cs_n` go low together on the next cycle and stay low for exactly PULSE_CYC cycles.
- R2: Two successive falls of `conv_n` are at least THRU_CYC cycles apart. When `start` is held high and every conversion finishes normally, they are exactly THRU_CYC cycles apart, and a `start` seen during a conversion has no other effect.
- R3: While `start` is low, `conv_n` and `cs_n` stay high.
- R4: Each synchronized rising edge of `dclk` captures one `sdata` bit, up to 12 per conversion. The first captured bit lands in `word[11]` and the twelfth in `word[0]`.
- R5: When `busy` rises after 12 bits have been captured, `word_valid` is high for exactly one cycle, 3 cycles after the rise. `word` then holds the 12 captured bits.
- R6: `tag` presents the level of `sdata` at the synchronized rise of `busy`. This is the level the line holds after the twelfth pulse.
- R7: `first_invalid` is high together with the first `word_valid` after reset, and is low on every later `word_valid`.
- R8: If `busy` rises after fewer than 12 captured bits, `err_short` pulses for one cycle, 3 cycles after the rise, and no `word_valid` is issued.
- R9: If `busy` does not rise within BUSY_TMO cycles after `conv_n` returns high, `err_timeout` pulses for one cycle, exactly BUSY_TMO cycles after `conv_n` returned high.
- R10: During reset, `conv_n` and `cs_n` are high, and `word_valid`, `first_invalid`, `err_short`, `err_timeout` and `word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run conversions |
| busy | input | 1 | Converter busy flag, low while converting |
| dclk | input | 1 | Data clock driven by the converter |
| sdata | input | 1 | Serial data from the converter |
| conv_n | output | 1 | Convert request, active low |
| cs_n | output | 1 | Chip select, active low |
| word | output | 12 | Captured result |
| tag | output | 1 | Captured tag bit |
| word_valid | output | 1 | One-cycle pulse when `word` and `tag` are new |
| first_invalid | output | 1 | Marks the first word after reset as meaningless |
| err_short | output | 1 | One-cycle pulse: busy rose with fewer than 12 bits |
| err_timeout | output | 1 | One-cycle pulse: busy did not rise in time |

## Verification
Each input change is taken as the cycle in which the bench drives it. The busy rise shows up as `word_valid` or `err_short` exactly 3 cycles later: two synchronizer stages plus the state register. The bench samples on the falling edge of that third cycle and compares against the cycle index it recorded when it drove busy. `err_timeout` is expected exactly BUSY_TMO cycles after `conv_n` is seen high again. The convert pulse width and the start-to-start spacing are counted in whole cycles from the falling edge of `conv_n`. Every comparison is made at the falling clock edge, so the bench never races the registers that produce the outputs.

// File: rtl/adccap_pkg.sv
package adccap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_DONE,
        ST_FAIL
    } cap_state_t;

    typedef enum logic [1:0] {
        FC_NONE,
        FC_TMO,
        FC_SHORT
    } fail_cause_t;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/cap_shift.sv
module cap_shift #(
    parameter int NBITS = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         en,
    input  logic                         stb,
    input  logic                         din,
    output logic [NBITS-1:0]             word,
    output logic [$clog2(NBITS+1)-1:0]   cnt
);
    localparam int CW = $clog2(NBITS + 1);
    localparam logic [CW-1:0] FULL = CW'(NBITS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else if (clr) begin
            word <= '0;
            cnt  <= '0;
        end else if (en && stb && cnt != FULL) begin
            word <= {word[NBITS-2:0], din};
            cnt  <= cnt + 1'b1;
        end
    end

    // R4: never more than NBITS bits per conversion
    a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
endmodule

// File: rtl/adc_serial_cap.sv
module adc_serial_cap
    import adccap_pkg::*;
#(
    parameter int NBITS     = 12,
    parameter int PULSE_CYC = 8,
    parameter int BUSY_TMO  = 3000,
    parameter int THRU_CYC  = 3200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             busy,
    input  logic             dclk,
    input  logic             sdata,
    output logic             conv_n,
    output logic             cs_n,
    output logic [NBITS-1:0] word,
    output logic             tag,
    output logic             word_valid,
    output logic             first_invalid,
    output logic             err_short,
    output logic             err_timeout
);
    localparam int CW = $clog2(NBITS + 1);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam int TW = $clog2(BUSY_TMO + 1);
    localparam int GW = $clog2(THRU_CYC + 1);
    localparam logic [CW-1:0] FULL   = CW'(NBITS);
    localparam logic [PW-1:0] P_LAST = PW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] T_LAST = TW'(BUSY_TMO - 1);
    localparam logic [GW-1:0] G_LOAD = GW'(THRU_CYC - 1);

    cap_state_t  state_q, state_d;
    fail_cause_t cause_q;

    logic [2:0]       sync_q;
    logic [1:0]       edge_q;
    logic             busy_rise, dclk_rise, sd_s;
    logic [PW-1:0]    pulse_cnt;
    logic [TW-1:0]    wait_cnt;
    logic [GW-1:0]    gap_cnt;
    logic [NBITS-1:0] sh_word;
    logic [CW-1:0]    bit_cnt;
    logic             launch, first_pend;

    cap_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({busy, dclk, sdata}),
        .q    (sync_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= 2'b00;
        else        edge_q <= sync_q[2:1];
    end

    assign busy_rise = sync_q[2] & ~edge_q[1];
    assign dclk_rise = sync_q[1] & ~edge_q[0];
    assign sd_s      = sync_q[0];
    assign launch    = (state_q == ST_IDLE) && (state_d == ST_CONV);

    cap_shift #(.NBITS(NBITS)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (launch),
        .en   ((state_q == ST_CONV) || (state_q == ST_WAIT)),
        .stb  (dclk_rise),
        .din  (sd_s),
        .word (sh_word),
        .cnt  (bit_cnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && gap_cnt == '0) state_d = ST_CONV;
            ST_CONV: if (pulse_cnt == P_LAST)    state_d = ST_WAIT;
            ST_WAIT: begin
                if (busy_rise)                   state_d = (bit_cnt == FULL) ? ST_DONE : ST_FAIL;
                else if (wait_cnt == T_LAST)     state_d = ST_FAIL;
            end
            ST_DONE: state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cause_q    <= FC_NONE;
            pulse_cnt  <= '0;
            wait_cnt   <= '0;
            gap_cnt    <= '0;
            word       <= '0;
            tag        <= 1'b0;
            first_pend <= 1'b1;
        end else begin
            state_q   <= state_d;
            pulse_cnt <= (state_q == ST_CONV) ? pulse_cnt + 1'b1 : '0;
            wait_cnt  <= (state_q == ST_WAIT) ? wait_cnt + 1'b1 : '0;
            if (launch)              gap_cnt <= G_LOAD;
            else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
            if (state_q == ST_WAIT && state_d == ST_FAIL)
                cause_q <= busy_rise ? FC_SHORT : FC_TMO;
            if (state_q == ST_WAIT && state_d == ST_DONE) begin
                word <= sh_word;
                tag  <= sd_s;
            end
            if (state_q == ST_DONE) first_pend <= 1'b0;
        end
    end

    // outputs decoded from the state
    always_comb begin
        conv_n        = 1'b1;
        cs_n          = 1'b1;
        word_valid    = 1'b0;
        first_invalid = 1'b0;
        err_short     = 1'b0;
        err_timeout   = 1'b0;
        unique case (state_q)
            ST_CONV: begin
                conv_n = 1'b0;
                cs_n   = 1'b0;
            end
            ST_DONE: begin
                word_valid    = 1'b1;
                first_invalid = first_pend;
            end
            ST_FAIL: begin
                err_short   = (cause_q == FC_SHORT);
                err_timeout = (cause_q == FC_TMO);
            end
            default: ;
        endcase
    end

    // R1: pulse never outlives its programmed width
    a_r1_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV) |-> (pulse_cnt < PW'(PULSE_CYC)));
    // R2: a new convert pulse only after the interval has run out
    a_r2_gap_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n) |-> ($past(gap_cnt) == '0));
    // R5: valid is a single-cycle pulse
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
    // R5: a word is only presented with all bits captured
    a_r5_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (bit_cnt == FULL));
    // R9: waiting never exceeds the timeout window
    a_r9_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (wait_cnt < TW'(BUSY_TMO)));
endmodule

// File: tb/sim_adc_serial_cap.sv
module sim_adc_serial_cap;
    localparam int PULSE = 4;
    localparam int TMO   = 400;
    localparam int THRU  = 300;
    localparam int NCONV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy = 1'b1;
    logic dclk = 1'b0;
    logic sdata = 1'b0;
    logic conv_n, cs_n, tag, word_valid, first_invalid, err_short, err_timeout;
    logic [11:0] word;

    adc_serial_cap #(.NBITS(12), .PULSE_CYC(PULSE), .BUSY_TMO(TMO), .THRU_CYC(THRU)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .dclk(dclk),
        .sdata(sdata), .conv_n(conv_n), .cs_n(cs_n), .word(word), .tag(tag),
        .word_valid(word_valid), .first_invalid(first_invalid),
        .err_short(err_short), .err_timeout(err_timeout)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errs = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    // conversion kind: 0 normal, 1 short burst, 2 busy never rises
    function automatic int kind_of(input int k);
        if (k == 3) return 1;
        if (k == 5) return 2;
        return 0;
    endfunction

    function automatic logic [11:0] word_of(input int k);
        case (k)
            0: return 12'hFFF;
            1: return 12'h000;
            2: return 12'hA55;
            4: return 12'h801;
            default: return 12'($urandom);
        endcase
    endfunction

    int nconv = 0;
    int nvalid = 0;
    int exp_kind = 0;
    int busy_cyc = 0;
    int conv_end_cyc = 0;
    int last_fall = -1;
    int last_kind = 0;
    logic [11:0] exp_word = '0;
    logic exp_tag = 1'b0;
    bit exp_first = 1'b1;
    bit had_valid = 0;

    // converter model
    initial begin
        void'($urandom(32'd4711));
        forever begin
            @(negedge clk);
            if (rst_n && conv_n == 1'b0 && cs_n == 1'b0) begin
                int pw;
                int kind;
                int np;
                logic [11:0] val;
                logic tb;
                pw = 0;
                if (last_fall >= 0) begin
                    chk((cyc - last_fall) >= THRU, "R2", "start spacing min", cyc - last_fall, THRU);
                    if (last_kind == 0)
                        chk((cyc - last_fall) == THRU, "R2", "start spacing held", cyc - last_fall, THRU);
                end
                last_fall = cyc;
                chk(cs_n == conv_n, "R1", "cs_n with conv_n", int'(cs_n), int'(conv_n));
                while (conv_n == 1'b0) begin
                    pw++;
                    @(negedge clk);
                end
                chk(pw == PULSE, "R1", "pulse width", pw, PULSE);
                conv_end_cyc = cyc;
                kind = kind_of(nconv);
                val = word_of(nconv);
                tb = 1'($urandom);
                last_kind = kind;
                busy = 1'b0;
                repeat (6) @(negedge clk);
                np = (kind == 1) ? 10 : 12;
                for (int i = 0; i < np; i++) begin
                    sdata = val[11 - i];
                    repeat (4) @(negedge clk);
                    dclk = 1'b1;
                    repeat (4) @(negedge clk);
                    dclk = 1'b0;
                end
                sdata = tb;
                repeat (8) @(negedge clk);
                exp_kind = kind;
                exp_word = val;
                exp_tag = tb;
                exp_first = !had_valid;
                if (kind == 0) had_valid = 1;
                if (kind != 2) begin
                    busy = 1'b1;
                    busy_cyc = cyc;
                end else begin
                    while (!err_timeout) @(negedge clk);
                    busy = 1'b1;
                end
                nconv++;
            end
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid) begin
                nvalid++;
                chk(exp_kind == 0, "R8", "valid after normal only", exp_kind, 0);
                chk(cyc == busy_cyc + 3, "R5", "valid latency", cyc - busy_cyc, 3);
                chk(word == exp_word, "R4", "word msb first", int'(word), int'(exp_word));
                chk(tag == exp_tag, "R6", "tag bit", int'(tag), int'(exp_tag));
                chk(first_invalid == exp_first, "R7", "first marker", int'(first_invalid), int'(exp_first));
            end
            if (err_short) begin
                chk(exp_kind == 1, "R8", "short error cause", exp_kind, 1);
                chk(cyc == busy_cyc + 3, "R8", "short error latency", cyc - busy_cyc, 3);
            end
            if (err_timeout) begin
                chk(exp_kind == 2, "R9", "timeout cause", exp_kind, 2);
                chk(cyc == conv_end_cyc + TMO, "R9", "timeout latency", cyc - conv_end_cyc, TMO);
            end
        end
    end

    // main sequence
    initial begin
        repeat (5) @(negedge clk);
        chk(conv_n && cs_n, "R10", "select lines idle in reset", int'({conv_n, cs_n}), 3);
        chk(!word_valid && !first_invalid, "R10", "valid flags in reset", int'({word_valid, first_invalid}), 0);
        chk(!err_short && !err_timeout, "R10", "errors in reset", int'({err_short, err_timeout}), 0);
        chk(word == 12'h000, "R10", "word in reset", int'(word), 0);
        rst_n = 1'b1;
        begin
            bit seen_low;
            seen_low = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!conv_n || !cs_n) seen_low = 1;
            end
            chk(!seen_low, "R3", "no conversion with start low", int'(seen_low), 0);
        end
        start = 1'b1;
        while (nconv < NCONV) @(negedge clk);
        start = 1'b0;
        repeat (500) @(negedge clk);
        chk(nvalid == NCONV - 2, "R5", "number of words", nvalid, NCONV - 2);
        summary();
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d conversions", nconv, NCONV);
        summary();
    end
endmodule